// File: doc/BRIEF.md
# Write-Completion Status Read Responder

This block is the read-data path of a parallel nonvolatile memory while an internal programming cycle may be running. It takes the chip-enable and output-enable pins (active low, asynchronous), synchronizes them, and drives the data bus only while both are low. When the pad driver is released, the data lines are held at zero.

When no programming cycle is running, a read returns the array word unchanged. While the write logic reports busy, the two upper bits of a read carry completion status. The top bit is the inverse of the top bit of the last byte written, which gives the host a polling test. The next bit inverts once per read access, which gives the host a toggle test. The lower bits pass through from the array. A write that was rejected because the memory is protected turns off the polling inversion until the next accepted write.

The write logic supplies only the top bit of each accepted byte, because that is the only stored bit the status path ever shows. Programming timing comes from outside through the busy input.

Top module: `prog_status_reader`

## Requirements
- R1: `bus_en` is 1 exactly while both `ce_n` and `oe_n` are low, delayed by SYNC_STAGES+1 rising clock edges (3 with defaults). Whenever `bus_en` is 0, `bus_data` is all zeros.
- R2: On a read with `busy` low, `bus_data` equals `array_rdata`. While the read is held, `bus_data` follows changes on `array_rdata` one edge later.
- R3: On a read with `busy` high and polling not suppressed, bit 7 of `bus_data` is the inverse of the last `wr_top_bit` captured with `wr_we`.
- R4: While `busy` is high, bit 6 of `bus_data` inverts once at the start of each read access and stays constant while that access is held. An access starts when the combined enable (both pins low) becomes active, and this includes `oe_n` falling while `ce_n` stays low.
- R5: A rising edge of `busy` clears the toggle state to 0, so the first read of each programming cycle returns bit 6 = 1.
- R6: On a read with `busy` high, bits 5:0 of `bus_data` equal bits 5:0 of `array_rdata`.
- R7: A one-cycle `prot_fail` pulse marks a write rejected in the protected state. From that pulse until the next `wr_we`, busy reads return bit 7 taken from `array_rdata`, with no inversion.
- R8: After reset, `bus_en` is 0 and `bus_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| busy | input | 1 | Programming cycle in progress (synchronous, from the write logic) |
| wr_we | input | 1 | One-cycle pulse: a byte was accepted for programming |
| wr_top_bit | input | 1 | Bit 7 of the accepted byte, valid with `wr_we` |
| prot_fail | input | 1 | One-cycle pulse: a write was rejected in the protected state |
| array_rdata | input | 8 | Array read word |
| bus_en | output | 1 | Pad output enable; 0 means the bus is high impedance |
| bus_data | output | 8 | Data to the pads |

## Verification
Pin changes on `ce_n` and `oe_n` reach `bus_en` after three rising edges. Changes on `busy`, `array_rdata` and the write pulses reach `bus_data` after one edge. The bench drives every input on the falling clock edge and waits five falling edges before it samples, so every result is settled when it is read. During a held read it also changes the array word and samples again after three edges. This shows that the data tracks the array while the toggle bit holds.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef struct packed {
        logic busy;   // busy seen at the previous edge
        logic rd;     // combined read enable at the previous edge
        logic tog;    // toggle status bit
        logic poll;   // top bit of the last accepted byte
        logic supp;   // polling suppressed after a rejected write
    } trk_t;

    localparam trk_t TRK_RST = '{busy: 1'b0, rd: 1'b0, tog: 1'b0, poll: 1'b0, supp: 1'b0};

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
    parameter int                 WIDTH   = 2,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] sh_d;
        logic [STAGES-1:0] sh_q;

        if (STAGES > 1) begin : g_multi
            always_comb sh_d = {sh_q[STAGES-2:0], din[b]};
        end else begin : g_single
            always_comb sh_d = din[b];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {STAGES{RST_VAL[b]}};
            else        sh_q <= sh_d;
        end

        assign dout[b] = sh_q[STAGES-1];
    end

endmodule

// File: rtl/psr_track.sv
module psr_track
    import psr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_act,
    input  logic busy,
    input  logic wr_we,
    input  logic wr_top_bit,
    input  logic prot_fail,
    output logic rd_start,
    output logic busy_rise,
    output logic tog_q,
    output logic tog_d,
    output logic poll_d,
    output logic supp_d
);

    trk_t st_d;
    trk_t st_q;

    always_comb begin
        st_d      = st_q;
        rd_start  = rd_act & ~st_q.rd;
        busy_rise = busy & ~st_q.busy;

        st_d.busy = busy;
        st_d.rd   = rd_act;

        // new programming cycle restarts the toggle, then a read may advance it
        st_d.tog  = (busy_rise ? 1'b0 : st_q.tog) ^ (rd_start & busy);

        if (wr_we) begin
            st_d.poll = wr_top_bit;
            st_d.supp = 1'b0;
        end else if (prot_fail) begin
            st_d.supp = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRK_RST;
        else        st_q <= st_d;
    end

    assign tog_q  = st_q.tog;
    assign tog_d  = st_d.tog;
    assign poll_d = st_d.poll;
    assign supp_d = st_d.supp;

endmodule

// File: rtl/psr_datasel.sv
module psr_datasel #(
    parameter int DATA_W = 8
) (
    input  logic              en,
    input  logic              busy,
    input  logic              poll,
    input  logic              supp,
    input  logic              tog,
    input  logic [DATA_W-1:0] arr,
    output logic [DATA_W-1:0] data
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    always_comb begin
        data = '0;
        if (en) begin
            data = arr;
            if (busy) begin
                data[POLL_BIT] = supp ? arr[POLL_BIT] : ~poll;
                data[TOG_BIT]  = tog;
            end
        end
    end

endmodule

// File: rtl/prog_status_reader.sv
module prog_status_reader #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              busy,
    input  logic              wr_we,
    input  logic              wr_top_bit,
    input  logic              prot_fail,
    input  logic [DATA_W-1:0] array_rdata,
    output logic              bus_en,
    output logic [DATA_W-1:0] bus_data
);

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] data;
    } out_t;

    logic [1:0]        pins_s;
    logic              rd_act;
    logic              rd_start;
    logic              busy_rise;
    logic              tog_q;
    logic              tog_d;
    logic              poll_d;
    logic              supp_d;
    logic [DATA_W-1:0] sel_data;
    out_t              out_d;
    out_t              out_q;

    psr_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ce_n, oe_n}),
        .dout  (pins_s)
    );

    assign rd_act = ~pins_s[1] & ~pins_s[0];

    psr_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_act     (rd_act),
        .busy       (busy),
        .wr_we      (wr_we),
        .wr_top_bit (wr_top_bit),
        .prot_fail  (prot_fail),
        .rd_start   (rd_start),
        .busy_rise  (busy_rise),
        .tog_q      (tog_q),
        .tog_d      (tog_d),
        .poll_d     (poll_d),
        .supp_d     (supp_d)
    );

    psr_datasel #(.DATA_W(DATA_W)) u_sel (
        .en   (rd_act),
        .busy (busy),
        .poll (poll_d),
        .supp (supp_d),
        .tog  (tog_d),
        .arr  (array_rdata),
        .data (sel_data)
    );

    always_comb begin
        out_d.en   = rd_act;
        out_d.data = sel_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bus_en   = out_q.en;
    assign bus_data = out_q.data;

endmodule

// File: rtl/prog_status_reader_chk.sv
module prog_status_reader_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_act,
    input logic              busy,
    input logic              rd_start,
    input logic              busy_rise,
    input logic              tog_q,
    input logic              poll_d,
    input logic              supp_d,
    input logic [DATA_W-1:0] array_rdata,
    input logic              bus_en,
    input logic [DATA_W-1:0] bus_data
);

    // R1
    released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> bus_data == '0);

    // R1
    enable_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> bus_en);

    // R1
    disable_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> !bus_en);

    // R2
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !busy) |=> bus_data == $past(array_rdata));

    // R3
    poll_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && busy && !supp_d) |=> bus_data[DATA_W-1] == !$past(poll_d));

    // R4
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_start && !busy_rise) |=> $stable(tog_q));

    // R4
    tog_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && busy && !busy_rise) |=> tog_q != $past(tog_q));

    // R5
    tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_rise && !rd_start) |=> !tog_q);

endmodule

bind prog_status_reader prog_status_reader_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_act      (rd_act),
    .busy        (busy),
    .rd_start    (rd_start),
    .busy_rise   (busy_rise),
    .tog_q       (tog_q),
    .poll_d      (poll_d),
    .supp_d      (supp_d),
    .array_rdata (array_rdata),
    .bus_en      (bus_en),
    .bus_data    (bus_data)
);

// File: tb/prog_status_reader_tb.sv
module prog_status_reader_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       busy = 1'b0;
    logic       wr_we = 1'b0;
    logic       wr_top_bit = 1'b0;
    logic       prot_fail = 1'b0;
    logic [7:0] array_rdata = 8'h00;
    logic       bus_en;
    logic [7:0] bus_data;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    bit m_busy = 0;
    bit m_tog  = 0;
    bit m_poll = 0;
    bit m_supp = 0;

    always #5 clk = ~clk;

    prog_status_reader u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
        .wr_we(wr_we), .wr_top_bit(wr_top_bit), .prot_fail(prot_fail),
        .array_rdata(array_rdata), .bus_en(bus_en), .bus_data(bus_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_word(input logic [7:0] arr);
        logic [7:0] w;
        w = arr;
        if (m_busy) begin
            w[7] = m_supp ? arr[7] : ~m_poll;
            w[6] = m_tog;
        end
        return w;
    endfunction

    task automatic check_word(input logic [7:0] arr);
        logic [7:0] e;
        e = exp_word(arr);
        if (!m_busy) begin
            chk("R2 idle read", bus_data, e);
        end else begin
            if (m_supp) chk("R7 poll suppressed bit7", bus_data[7], e[7]);
            else        chk("R3 poll bit7", bus_data[7], e[7]);
            chk("R4 toggle bit6", bus_data[6], e[6]);
            chk("R6 low bits", bus_data[5:0], e[5:0]);
        end
    endtask

    task automatic do_read(input bit keep_ce, input logic [7:0] arr);
        logic [7:0] arr2;
        @(negedge clk);
        ce_n = 1'b0;
        oe_n = 1'b0;
        array_rdata = arr;
        if (m_busy) m_tog = ~m_tog;
        repeat (5) @(negedge clk);
        chk("R1 bus enabled", bus_en, 1'b1);
        check_word(arr);
        // held access: new array word, toggle must hold
        arr2 = 8'($urandom);
        array_rdata = arr2;
        repeat (3) @(negedge clk);
        check_word(arr2);
        oe_n = 1'b1;
        if (!keep_ce) ce_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 bus released", bus_en, 1'b0);
        chk("R1 released data zero", bus_data, 8'h00);
    endtask

    task automatic do_write(input logic [7:0] b);
        @(negedge clk);
        wr_we = 1'b1;
        wr_top_bit = b[7];
        @(negedge clk);
        wr_we = 1'b0;
        m_poll = b[7];
        m_supp = 0;
    endtask

    task automatic do_reject();
        @(negedge clk);
        prot_fail = 1'b1;
        @(negedge clk);
        prot_fail = 1'b0;
        m_supp = 1;
    endtask

    task automatic set_busy(input bit v);
        @(negedge clk);
        busy = v;
        if (v && !m_busy) m_tog = 0;
        m_busy = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R8 reset bus_en", bus_en, 1'b0);
        chk("R8 reset data", bus_data, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        do_read(0, 8'h5A);                         // R2
        do_write(8'h3C);
        set_busy(1);
        do_read(0, 8'h00);                         // R5: first busy read bit6=1, R3 bit7=1
        do_read(1, 8'hFF);                         // R4 second read, ce stays low
        do_read(0, 8'h81);                         // R4 oe-only access
        set_busy(0);
        do_read(0, 8'hC3);                         // R2 after completion
        do_write(8'hA5);
        do_reject();                               // R7
        set_busy(1);
        do_read(0, 8'h7E);
        do_read(0, 8'h80);
        do_write(8'h01);                           // clears suppression
        do_read(0, 8'h80);
        set_busy(0);

        // constrained random mix
        for (int i = 0; i < 150; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1:    do_write(8'($urandom));
                2:       do_reject();
                3:       set_busy(~m_busy);
                4:       do_read(1, 8'($urandom));
                default: do_read(0, 8'($urandom));
            endcase
        end
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 final release", bus_en, 1'b0);
        finish_run();
    end

endmodule